// File: doc/BRIEF.md
# Auto-Precharge Command Expander

This block sits in a memory controller's command path between the scheduler and the command issue stage. Each incoming command has a type, a bank and an issue cycle. A read or write with auto-precharge leaves the block as a plain read or write. The block then places an explicit precharge for the same bank into the outgoing stream, at the cycle when that precharge would really take effect. Both ports use a valid/ready handshake. The incoming stream is expected in non-decreasing cycle order, and the outgoing stream keeps that order.

The block keeps one activation timestamp per bank. The precharge cycle is the later of two values: the read or write cycle plus a per-type offset, and the bank's last activation cycle plus the minimum row-active time. Pending precharges wait in a schedule that holds one slot per bank. A precharge is released when the next incoming command would otherwise pass it. When a command tagged as the last one is accepted, the schedule is drained in time order and a closing NOP marker follows. The marker's cycle is set by the completion time of the last emitted command.

Top module: `apx_expander`

## Requirements
- R1: Command encoding on both ports is NOP=0, ACT=1, RD=2, WR=3, RDA=4, WRA=5, PRE=6, PREA=7, REF=8. An RDA or WRA leaves the block as RD or WR with the same bank and cycle. Every other input command leaves the block unchanged.
- R2: Each accepted ACT records its cycle for its bank. An accepted RDA (or WRA) schedules a PRE for its bank at the later of (cycle + read offset, or write offset for WRA) and (recorded ACT cycle + T_RAS).
- R3: The read and write offsets are taken from `rd_pre_ofs` and `wr_pre_ofs` while `rst` is high. Any change on those inputs after reset has no effect.
- R4: A pending PRE is emitted before an input command whose cycle is equal to or later than the PRE's cycle, so on a tie the PRE goes first. An input command with an earlier cycle passes ahead of it. With no input present and no drain in progress, a pending PRE waits.
- R5: Several pending PREs leave in ascending cycle order. On equal cycles the lower bank leaves first.
- R6: An RDA or WRA accepted for a bank that already has a pending PRE pulses `dup_err` in its acceptance cycle. It is still forwarded as RD or WR, and the earlier PRE entry is kept unchanged.
- R7: Accepting a command with `in_last` set starts a drain. Input is blocked, all pending PREs are emitted, and then a NOP with bank 0 is emitted at (cycle of last emitted command + its completion time - 1).
- R8: Completion time is RL+DQSCK+1+BL/DATA_RATE for RD, WL+BL/DATA_RATE+T_WR for WR, T_RCD for ACT, T_RP for PRE and PREA, and 0 for any other command.
- R9: While `out_ready` is low, no input is accepted and the presented output stays unchanged.
- R10: After reset `out_valid` is low, the schedule is empty and no drain is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; offsets are captured while high |
| rd_pre_ofs | input | OFS_W | Precharge offset after an auto-precharge read |
| wr_pre_ofs | input | OFS_W | Precharge offset after an auto-precharge write |
| in_valid | input | 1 | Input command valid |
| in_ready | output | 1 | Input command accepted this cycle when valid |
| in_cmd | input | 4 | Input command type (R1 encoding) |
| in_bank | input | $clog2(NB) | Input bank |
| in_ts | input | TS_W | Input command cycle |
| in_last | input | 1 | Marks the final command of a stream |
| out_valid | output | 1 | Output command valid |
| out_ready | input | 1 | Downstream accepts output |
| out_cmd | output | 4 | Output command type |
| out_bank | output | $clog2(NB) | Output bank |
| out_ts | output | TS_W | Output command cycle |
| dup_err | output | 1 | Auto-precharge to a bank whose precharge is still pending |

## Verification
The contested cycle comes when a pending precharge and an incoming command both claim the single output slot. The bench provokes this by sweeping the read or write distance after activation across every bank. Each probe command is placed either exactly on the computed precharge cycle or one cycle before it. The emitted sequence is then judged against the order that R4 and R5 require: the precharge first on a tie, the probe first when it is earlier. A second case sets up two banks whose precharges fall on the same cycle and checks that the lower bank drains first.

// File: rtl/apx_pkg.sv
package apx_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_RDA  = 4'd4,
        CMD_WRA  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_PREA = 4'd7,
        CMD_REF  = 4'd8
    } apx_cmd_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_IN,
        SRC_PRE,
        SRC_NOP
    } apx_src_e;

    function automatic logic is_autopre(input apx_cmd_e c);
        return (c == CMD_RDA) || (c == CMD_WRA);
    endfunction

    function automatic apx_cmd_e strip_autopre(input apx_cmd_e c);
        case (c)
            CMD_RDA: return CMD_RD;
            CMD_WRA: return CMD_WR;
            default: return c;
        endcase
    endfunction

    function automatic int unsigned done_cycles(
        input apx_cmd_e    c,
        input int unsigned rl,
        input int unsigned dqsck,
        input int unsigned bl,
        input int unsigned rate,
        input int unsigned wl,
        input int unsigned twr,
        input int unsigned trcd,
        input int unsigned trp
    );
        case (c)
            CMD_RD:            return rl + dqsck + 1 + bl / rate;
            CMD_WR:            return wl + bl / rate + twr;
            CMD_ACT:           return trcd;
            CMD_PRE, CMD_PREA: return trp;
            default:           return 0;
        endcase
    endfunction

endpackage

// File: rtl/apx_act_table.sv
module apx_act_table #(
    parameter  int NB     = 8,
    parameter  int TS_W   = 32,
    localparam int BANK_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [TS_W-1:0]   wr_ts,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [TS_W-1:0]   rd_ts
);

    logic [TS_W-1:0] act_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                act_q[g] <= '0;
            end else if (wr_en && (wr_bank == BANK_W'(g))) begin
                act_q[g] <= wr_ts;
            end
        end
    end

    assign rd_ts = act_q[rd_bank];

    // R2
    act_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> act_q[$past(wr_bank)] == $past(wr_ts));

endmodule

// File: rtl/apx_pre_sched.sv
module apx_pre_sched #(
    parameter  int NB     = 8,
    parameter  int TS_W   = 32,
    localparam int BANK_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_en,
    input  logic [BANK_W-1:0] ins_bank,
    input  logic [TS_W-1:0]   ins_ts,
    input  logic              pop_en,
    output logic [NB-1:0]     occ_o,
    output logic              any_o,
    output logic [BANK_W-1:0] min_bank_o,
    output logic [TS_W-1:0]   min_ts_o
);

    logic            occ_q [NB];
    logic [TS_W-1:0] due_q [NB];

    // earliest pending entry; strict compare keeps the lower bank on ties
    always_comb begin
        any_o      = 1'b0;
        min_bank_o = '0;
        min_ts_o   = '0;
        for (int i = 0; i < NB; i++) begin
            if (occ_q[i] && (!any_o || (due_q[i] < min_ts_o))) begin
                any_o      = 1'b1;
                min_bank_o = BANK_W'(i);
                min_ts_o   = due_q[i];
            end
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q[g] <= 1'b0;
                due_q[g] <= '0;
            end else if (ins_en && (ins_bank == BANK_W'(g)) && !occ_q[g]) begin
                occ_q[g] <= 1'b1;
                due_q[g] <= ins_ts;
            end else if (pop_en && (min_bank_o == BANK_W'(g))) begin
                occ_q[g] <= 1'b0;
            end
        end
        assign occ_o[g] = occ_q[g];
    end

    // R5
    pop_occ_chk: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> occ_o[min_bank_o]);

    // R5
    pop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pop_en |=> !occ_o[$past(min_bank_o)]);

    // R6
    ins_free_chk: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> !occ_o[ins_bank]);

endmodule

// File: rtl/apx_flush_ctl.sv
module apx_flush_ctl
    import apx_pkg::*;
#(
    parameter int TS_W      = 32,
    parameter int RL        = 11,
    parameter int DQSCK     = 1,
    parameter int BL        = 8,
    parameter int DATA_RATE = 2,
    parameter int WL        = 9,
    parameter int T_WR      = 12,
    parameter int T_RCD     = 11,
    parameter int T_RP      = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  apx_cmd_e        fire_cmd,
    input  logic [TS_W-1:0] fire_ts,
    input  logic            last_acc,
    input  logic            nop_fire,
    output logic            draining,
    output logic [TS_W-1:0] nop_ts
);

    logic            drain_q;
    logic            have_q;
    apx_cmd_e        last_cmd_q;
    logic [TS_W-1:0] last_ts_q;
    int unsigned     tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            drain_q    <= 1'b0;
            have_q     <= 1'b0;
            last_cmd_q <= CMD_NOP;
            last_ts_q  <= '0;
        end else begin
            if (last_acc) begin
                drain_q <= 1'b1;
            end else if (nop_fire) begin
                drain_q <= 1'b0;
            end
            if (fire) begin
                last_cmd_q <= fire_cmd;
                last_ts_q  <= fire_ts;
                have_q     <= !nop_fire;
            end
        end
    end

    always_comb begin
        tail = done_cycles(last_cmd_q, RL, DQSCK, BL, DATA_RATE, WL, T_WR, T_RCD, T_RP);
        nop_ts = last_ts_q + TS_W'(tail) - TS_W'(1);
    end

    assign draining = drain_q;

    // R4
    ts_order_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && have_q && (fire_cmd != CMD_NOP)) |-> (fire_ts >= last_ts_q));

    // R7
    nop_drain_chk: assert property (@(posedge clk) disable iff (rst)
        nop_fire |-> drain_q);

endmodule

// File: rtl/apx_expander.sv
module apx_expander
    import apx_pkg::*;
#(
    parameter  int NB        = 8,
    parameter  int TS_W      = 32,
    parameter  int OFS_W     = 8,
    parameter  int T_RAS     = 28,
    parameter  int RL        = 11,
    parameter  int DQSCK     = 1,
    parameter  int BL        = 8,
    parameter  int DATA_RATE = 2,
    parameter  int WL        = 9,
    parameter  int T_WR      = 12,
    parameter  int T_RCD     = 11,
    parameter  int T_RP      = 11,
    localparam int BANK_W    = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  rd_pre_ofs,
    input  logic [OFS_W-1:0]  wr_pre_ofs,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [TS_W-1:0]   in_ts,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CMD_W-1:0]  out_cmd,
    output logic [BANK_W-1:0] out_bank,
    output logic [TS_W-1:0]   out_ts,
    output logic              dup_err
);

    logic [OFS_W-1:0]  rd_ofs_q, wr_ofs_q;
    apx_cmd_e          in_cmd_e, out_cmd_e;
    logic              in_ap, in_acc, fire;
    logic [TS_W-1:0]   act_ts, by_cmd, by_ras, due_ts;
    logic [NB-1:0]     occ;
    logic              sch_any, pre_first, draining;
    logic [BANK_W-1:0] sch_bank;
    logic [TS_W-1:0]   sch_ts, nop_ts;
    apx_src_e          src;

    // offsets follow their inputs only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ofs_q <= rd_pre_ofs;
            wr_ofs_q <= wr_pre_ofs;
        end
    end

    assign in_cmd_e = apx_cmd_e'(in_cmd);
    assign in_ap    = is_autopre(in_cmd_e);

    always_comb begin
        by_cmd = in_ts + TS_W'((in_cmd_e == CMD_WRA) ? wr_ofs_q : rd_ofs_q);
        by_ras = act_ts + TS_W'(T_RAS);
        due_ts = (by_cmd > by_ras) ? by_cmd : by_ras;
    end

    always_comb begin
        pre_first = sch_any && (draining || (in_valid && (in_ts >= sch_ts)));
        if (pre_first)     src = SRC_PRE;
        else if (draining) src = SRC_NOP;
        else if (in_valid) src = SRC_IN;
        else               src = SRC_NONE;
    end

    always_comb begin
        out_cmd_e = CMD_NOP;
        out_bank  = '0;
        out_ts    = '0;
        case (src)
            SRC_PRE: begin
                out_cmd_e = CMD_PRE;
                out_bank  = sch_bank;
                out_ts    = sch_ts;
            end
            SRC_NOP: begin
                out_ts = nop_ts;
            end
            SRC_IN: begin
                out_cmd_e = strip_autopre(in_cmd_e);
                out_bank  = in_bank;
                out_ts    = in_ts;
            end
            default: ;
        endcase
    end

    assign out_cmd   = out_cmd_e;
    assign out_valid = (src != SRC_NONE);
    assign fire      = out_valid && out_ready;
    assign in_ready  = out_ready && (src == SRC_IN);
    assign in_acc    = in_valid && in_ready;
    assign dup_err   = in_acc && in_ap && occ[in_bank];

    apx_act_table #(.NB(NB), .TS_W(TS_W)) u_act (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_acc && (in_cmd_e == CMD_ACT)),
        .wr_bank (in_bank),
        .wr_ts   (in_ts),
        .rd_bank (in_bank),
        .rd_ts   (act_ts)
    );

    apx_pre_sched #(.NB(NB), .TS_W(TS_W)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .ins_en     (in_acc && in_ap && !occ[in_bank]),
        .ins_bank   (in_bank),
        .ins_ts     (due_ts),
        .pop_en     (fire && (src == SRC_PRE)),
        .occ_o      (occ),
        .any_o      (sch_any),
        .min_bank_o (sch_bank),
        .min_ts_o   (sch_ts)
    );

    apx_flush_ctl #(
        .TS_W(TS_W), .RL(RL), .DQSCK(DQSCK), .BL(BL), .DATA_RATE(DATA_RATE),
        .WL(WL), .T_WR(T_WR), .T_RCD(T_RCD), .T_RP(T_RP)
    ) u_flush (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .fire_cmd (out_cmd_e),
        .fire_ts  (out_ts),
        .last_acc (in_acc && in_last),
        .nop_fire (fire && (src == SRC_NOP)),
        .draining (draining),
        .nop_ts   (nop_ts)
    );

    // R1
    out_plain_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !is_autopre(apx_cmd_e'(out_cmd)));

    // R7
    in_block_chk: assert property (@(posedge clk) disable iff (rst)
        in_acc |-> !draining);

    // R6
    dup_keep_chk: assert property (@(posedge clk) disable iff (rst)
        dup_err |=> occ[$past(in_bank)]);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && (src != SRC_IN)) |=> (out_valid && $stable(out_ts)));

    // R10
    rst_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sch_any && !draining));

endmodule

// File: tb/tb_apx_expander.sv
module tb_apx_expander;

    localparam int NB = 4;
    localparam int TS_W = 16;
    localparam int BW = 2;
    localparam int EXP_MAX = 1024;
    // R1 encoding
    localparam logic [3:0] C_NOP = 4'd0, C_ACT = 4'd1, C_RD = 4'd2, C_WR = 4'd3,
                           C_RDA = 4'd4, C_WRA = 4'd5, C_PRE = 4'd6;
    // R8 completion times with the default timing
    localparam int D_RD = 11 + 1 + 1 + 8 / 2;
    localparam int D_WR = 9 + 8 / 2 + 12;
    localparam int D_ACT = 11;
    localparam int D_PRE = 11;
    localparam int RAS = 28;
    localparam int OFS_RD = 4, OFS_WR = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] rd_pre_ofs = 8'(OFS_RD), wr_pre_ofs = 8'(OFS_WR);
    logic in_valid = 1'b0, in_ready, in_last = 1'b0;
    logic [3:0] in_cmd = '0;
    logic [BW-1:0] in_bank = '0;
    logic [TS_W-1:0] in_ts = '0;
    logic out_valid, out_ready = 1'b1, dup_err;
    logic [3:0] out_cmd;
    logic [BW-1:0] out_bank;
    logic [TS_W-1:0] out_ts;

    always #2.5 clk = ~clk;

    apx_expander #(.NB(NB), .TS_W(TS_W), .OFS_W(8), .T_RAS(RAS)) dut (
        .clk(clk), .rst(rst), .rd_pre_ofs(rd_pre_ofs), .wr_pre_ofs(wr_pre_ofs),
        .in_valid(in_valid), .in_ready(in_ready), .in_cmd(in_cmd), .in_bank(in_bank),
        .in_ts(in_ts), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_cmd(out_cmd), .out_bank(out_bank), .out_ts(out_ts), .dup_err(dup_err)
    );

    int errors = 0, checks = 0;
    int n_exp = 0, n_got = 0, dup_cnt = 0, dup_ts = 0;
    logic [3:0]  e_cmd [EXP_MAX], g_cmd [EXP_MAX];
    int          e_bank [EXP_MAX], g_bank [EXP_MAX];
    int          e_ts [EXP_MAX], g_ts [EXP_MAX];
    string       e_tag [EXP_MAX];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input int b, input int t, input string tag);
        e_cmd[n_exp] = c; e_bank[n_exp] = b; e_ts[n_exp] = t; e_tag[n_exp] = tag;
        n_exp++;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready && n_got < EXP_MAX) begin
            g_cmd[n_got] = out_cmd; g_bank[n_got] = int'(out_bank); g_ts[n_got] = int'(out_ts);
            n_got++;
        end
        if (!rst && in_valid && in_ready && dup_err) begin
            dup_cnt++; dup_ts = int'(in_ts);
        end
    end

    task automatic send(input logic [3:0] c, input int b, input int t, input bit last);
        in_valid = 1'b1; in_cmd = c; in_bank = BW'(b); in_ts = TS_W'(t); in_last = last;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            if (out_valid) quiet = 0; else quiet++;
        end
        @(posedge clk); #1;
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_all();
        int base;
        // R10: reset state
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b0, "R10 in_ready idle after reset", int'(in_ready), 0);
        @(posedge clk); #1;

        // S1: R1 R2 R7 R8, ACT-bound precharge
        send(C_ACT, 0, 10, 0);  push(C_ACT, 0, 10, "R1");
        send(C_RDA, 0, 20, 0);  push(C_RD, 0, 20, "R1");
        send(C_ACT, 1, 30, 0);  push(C_ACT, 1, 30, "R4");
        send(C_WR, 1, 40, 1);   push(C_PRE, 0, mx(20 + OFS_RD, 10 + RAS), "R2");
                                push(C_WR, 1, 40, "R4");
                                push(C_NOP, 0, 40 + D_WR - 1, "R8");

        // S2: tie between pending PRE and input (R4)
        send(C_ACT, 2, 100, 0); push(C_ACT, 2, 100, "R1");
        send(C_WRA, 2, 200, 0); push(C_WR, 2, 200, "R1");
        send(C_RD, 3, 206, 1);  push(C_PRE, 2, mx(200 + OFS_WR, 100 + RAS), "R4");
                                push(C_RD, 3, 206, "R4");
                                push(C_NOP, 0, 206 + D_RD - 1, "R7");

        // S3: duplicate and same-cycle drain (R5 R6)
        send(C_ACT, 1, 301, 0); push(C_ACT, 1, 301, "R1");
        send(C_ACT, 3, 301, 0); push(C_ACT, 3, 301, "R1");
        send(C_RDA, 3, 302, 0); push(C_RD, 3, 302, "R1");
        send(C_RDA, 1, 303, 0); push(C_RD, 1, 303, "R1");
        send(C_WRA, 1, 304, 0); push(C_WR, 1, 304, "R6");
        send(C_ACT, 0, 305, 1); push(C_ACT, 0, 305, "R1");
                                push(C_PRE, 1, 329, "R5");
                                push(C_PRE, 3, 329, "R5");
                                push(C_NOP, 0, 329 + D_PRE - 1, "R7");
        wait_idle();
        check(dup_cnt == 1, "R6 dup_err pulse count", dup_cnt, 1);
        check(dup_ts == 304, "R6 dup_err on second auto-precharge", dup_ts, 304);

        // S4: offsets changed after reset (R3) and backpressure (R9)
        rd_pre_ofs = 8'd20; wr_pre_ofs = 8'd30;
        out_ready = 1'b0;
        in_valid = 1'b1; in_cmd = C_ACT; in_bank = '0; in_ts = 16'd400; in_last = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R9 no accept under backpressure", int'(in_ready), 0);
            check(out_valid && out_ts == 16'd400, "R9 output held", int'(out_ts), 400);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        send(C_ACT, 0, 400, 0); push(C_ACT, 0, 400, "R9");
        send(C_RDA, 0, 500, 0); push(C_RD, 0, 500, "R1");
        send(C_ACT, 1, 600, 1); push(C_PRE, 0, mx(500 + OFS_RD, 400 + RAS), "R3");
                                push(C_ACT, 1, 600, "R4");
                                push(C_NOP, 0, 600 + D_ACT - 1, "R8");
        rd_pre_ofs = 8'(OFS_RD); wr_pre_ofs = 8'(OFS_WR);

        // S5: sweep over banks and distances (R2 R4)
        base = 1000;
        for (int b = 0; b < NB; b++) begin
            for (int d = 0; d < 32; d++) begin
                bit wr = ((d % 4) >= 2);
                int pre = mx(base + d + (wr ? OFS_WR : OFS_RD), base + RAS);
                send(C_ACT, b, base, 0);              push(C_ACT, b, base, "R2");
                send(wr ? C_WRA : C_RDA, b, base + d, 0);
                push(wr ? C_WR : C_RD, b, base + d, "R1");
                if (d % 2 == 1) begin
                    send(C_RD, b, pre - 1, 1);
                    push(C_RD, b, pre - 1, "R4");
                    push(C_PRE, b, pre, "R2");
                    push(C_NOP, 0, pre + D_PRE - 1, "R7");
                end else begin
                    send(C_RD, b, pre, 1);
                    push(C_PRE, b, pre, "R4");
                    push(C_RD, b, pre, "R4");
                    push(C_NOP, 0, pre + D_RD - 1, "R7");
                end
                base += 100;
            end
        end
        wait_idle();

        check(n_got == n_exp, "R7 output count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(g_cmd[i] == e_cmd[i], {e_tag[i], " cmd"}, int'(g_cmd[i]), int'(e_cmd[i]));
            check(g_bank[i] == e_bank[i], {e_tag[i], " bank"}, g_bank[i], e_bank[i]);
            check(g_ts[i] == e_ts[i], {e_tag[i], " cycle"}, g_ts[i], e_ts[i]);
        end
        check(dup_cnt == 1, "R6 no further dup_err", dup_cnt, 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule